// File: doc/BRIEF.md
# Lane-Chunked Vector Issue Sequencer

This block executes one vector operation of logical length VL on a narrow bank of parallel ALU lanes. A start pulse captures the length and an operation class. The sequencer then walks through the elements in groups as wide as the lane bank, one group per cycle, in ascending element order. Each cycle it drives a valid bit and an element index per lane, which the lanes use to read their operands through indexed register ports. One cycle later, the same lanes get a write-back enable and the matching index. The number of groups depends only on the length, so the caller sees the same result as a fully parallel unit, only spread over more cycles.

A fixed, parameter-defined table marks some operation classes as uncommon. Those classes bypass the lane bank and go to a single shared unit, one element per cycle, with their own issue and write-back ports. Busy is held for the whole operation, and a new start pulse is ignored while busy is high. A one-cycle done pulse closes the operation.

Top module: `lane_chunk_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done and every issue and write-back valid are low.
- R2: For a common class, in issue cycle p (p = 0 for the first cycle after the start is accepted) lane k carries element index p*LANES+k. Passes follow one per cycle until every element below VL has been issued exactly once.
- R3: In the last pass of a length that is not a multiple of LANES, lanes whose index would be at or above VL show no issue valid and no write-back valid.
- R4: Every issue valid on a lane or on the shared unit is followed in the next cycle by a write-back valid on the same port with the same index. No write-back valid appears without that preceding issue.
- R5: For an uncommon class, the shared unit issues element i in issue cycle i, for i from 0 to VL-1, and no lane valid is raised during the operation.
- R6: The class is a 3-bit code. By default classes 6 and 7 are uncommon and classes 0 to 5 use the lane bank. The captured class is presented on the class output and held stable while busy.
- R7: A start with VL = 0 raises done in the first cycle after acceptance and raises no issue or write-back valid.
- R8: Busy rises in the cycle after a start is accepted and stays high through the done cycle. A start pulse while busy is high has no effect on any output.
- R9: Done is high for exactly one cycle. For VL > 0 that is the cycle right after the last write-back valid.
- R10: A requested VL above MAX_VL (default 16) is treated as MAX_VL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| vl_i | input | 5 | Requested vector length |
| class_i | input | 3 | Operation class |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| class_o | output | 3 | Captured class for the datapath |
| lane_vld_o | output | 4 | Per-lane issue valid |
| lane_idx_o | output | 16 | Per-lane element index, 4 bits per lane |
| one_vld_o | output | 1 | Shared-unit issue valid |
| one_idx_o | output | 4 | Shared-unit element index |
| lane_wb_o | output | 4 | Per-lane write-back enable |
| lane_wb_idx_o | output | 16 | Per-lane write-back index, 4 bits per lane |
| one_wb_o | output | 1 | Shared-unit write-back enable |
| one_wb_idx_o | output | 4 | Shared-unit write-back index |

## Verification
In every middle cycle of a multi-pass operation, the issue of pass p and the write-back of pass p-1 occur together. Operations of lengths 1 through 16, plus one over the limit, therefore hold both on the ports at once, and each cycle is compared against a length-driven reference model for both indices. The second overlap is a start pulse that arrives during issue or in the done cycle itself. Repeated and back-to-back start pulses provoke it, and the model's view of busy, done and every valid judges it, so that a swallowed or wrongly taken start shows up as a mismatch.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } lcs_state_e;

  // Limit a requested length to the largest supported length
  function automatic int unsigned clamp_len(input int unsigned req, input int unsigned cap);
    return (req > cap) ? cap : req;
  endfunction

  // Elements consumed per issue cycle for the chosen path
  function automatic int unsigned step_width(input logic single, input int unsigned lanes);
    return single ? 1 : lanes;
  endfunction

endpackage

// File: rtl/lcs_class_table.sv
module lcs_class_table #(
  parameter int          CW        = 3,
  parameter logic [(1<<CW)-1:0] RARE_MASK = '0
) (
  input  logic [CW-1:0] cls,
  output logic          single
);
  always_comb single = RARE_MASK[cls];
endmodule

// File: rtl/lcs_issue_ctrl.sv
module lcs_issue_ctrl
  import lcs_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int MAX_VL = 16,
  parameter int CW     = 3,
  parameter int VLW    = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vl_req,
  input  logic [CW-1:0]  cls_req,
  input  logic           single_req,
  output logic           accept,
  output logic           issuing,
  output logic           single_q,
  output logic [VLW-1:0] base_q,
  output logic [VLW-1:0] len_q,
  output logic [CW-1:0]  cls_q,
  output logic           busy,
  output logic           done
);
  localparam int SW = VLW + 1;

  lcs_state_e     state_q;
  logic [VLW-1:0] len_cl;
  logic [SW-1:0]  step;
  logic [SW-1:0]  next_base;

  always_comb begin
    len_cl    = VLW'(clamp_len(32'(vl_req), MAX_VL));
    step      = SW'(step_width(single_q, LANES));
    next_base = {1'b0, base_q} + step;
    accept    = start && (state_q == ST_IDLE);
    issuing   = (state_q == ST_ISSUE);
    busy      = (state_q != ST_IDLE);
    done      = (state_q == ST_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      base_q   <= '0;
      len_q    <= '0;
      cls_q    <= '0;
      single_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          len_q    <= len_cl;
          cls_q    <= cls_req;
          single_q <= single_req;
          base_q   <= '0;
          state_q  <= (len_cl == '0) ? ST_DONE : ST_ISSUE;
        end
        ST_ISSUE: begin
          if (next_base >= {1'b0, len_q}) state_q <= ST_DRAIN;
          else                            base_q  <= next_base[VLW-1:0];
        end
        ST_DRAIN: state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lcs_slot.sv
module lcs_slot #(
  parameter int OFFSET = 0,
  parameter int VLW    = 5,
  parameter int IW     = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [VLW-1:0] base,
  input  logic [VLW-1:0] len,
  output logic           iss_vld,
  output logic [IW-1:0]  iss_idx,
  output logic           wb_vld,
  output logic [IW-1:0]  wb_idx
);
  localparam int SW = VLW + 1;
  logic [SW-1:0] elem;

  always_comb begin
    elem    = {1'b0, base} + SW'(OFFSET);
    iss_vld = en && (elem < {1'b0, len});
    iss_idx = elem[IW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_vld <= 1'b0;
      wb_idx <= '0;
    end else begin
      wb_vld <= iss_vld;
      wb_idx <= iss_vld ? iss_idx : '0;
    end
  end
endmodule

// File: rtl/lane_chunk_sequencer.sv
module lane_chunk_sequencer #(
  parameter int LANES  = 4,
  parameter int MAX_VL = 16,
  parameter int CW     = 3,
  parameter logic [(1<<CW)-1:0] RARE_MASK = 8'b1100_0000,
  localparam int VLW   = $clog2(MAX_VL + 1),
  localparam int IW    = $clog2(MAX_VL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [VLW-1:0]     vl_i,
  input  logic [CW-1:0]      class_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [CW-1:0]      class_o,
  output logic [LANES-1:0]   lane_vld_o,
  output logic [LANES*IW-1:0] lane_idx_o,
  output logic               one_vld_o,
  output logic [IW-1:0]      one_idx_o,
  output logic [LANES-1:0]   lane_wb_o,
  output logic [LANES*IW-1:0] lane_wb_idx_o,
  output logic               one_wb_o,
  output logic [IW-1:0]      one_wb_idx_o
);
  logic           single_req;
  logic           accept_w;
  logic           issuing_w;
  logic           single_w;
  logic [VLW-1:0] base_w;
  logic [VLW-1:0] len_w;
  logic           bank_en_w;
  logic           one_en_w;
  logic           zero_start_w;

  lcs_class_table #(.CW(CW), .RARE_MASK(RARE_MASK)) u_table (
    .cls    (class_i),
    .single (single_req)
  );

  lcs_issue_ctrl #(.LANES(LANES), .MAX_VL(MAX_VL), .CW(CW), .VLW(VLW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_i),
    .vl_req     (vl_i),
    .cls_req    (class_i),
    .single_req (single_req),
    .accept     (accept_w),
    .issuing    (issuing_w),
    .single_q   (single_w),
    .base_q     (base_w),
    .len_q      (len_w),
    .cls_q      (class_o),
    .busy       (busy_o),
    .done       (done_o)
  );

  always_comb begin
    bank_en_w    = issuing_w && !single_w;
    one_en_w     = issuing_w && single_w;
    zero_start_w = accept_w && (vl_i == '0);
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lcs_slot #(.OFFSET(k), .VLW(VLW), .IW(IW)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (bank_en_w),
      .base    (base_w),
      .len     (len_w),
      .iss_vld (lane_vld_o[k]),
      .iss_idx (lane_idx_o[k*IW +: IW]),
      .wb_vld  (lane_wb_o[k]),
      .wb_idx  (lane_wb_idx_o[k*IW +: IW])
    );
  end

  lcs_slot #(.OFFSET(0), .VLW(VLW), .IW(IW)) u_one (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (one_en_w),
    .base    (base_w),
    .len     (len_w),
    .iss_vld (one_vld_o),
    .iss_idx (one_idx_o),
    .wb_vld  (one_wb_o),
    .wb_idx  (one_wb_idx_o)
  );
endmodule

// File: rtl/lcs_checker.sv
module lcs_checker #(
  parameter int LANES = 4,
  parameter int CW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_ok,
  input logic             zero_start,
  input logic             busy,
  input logic             done,
  input logic [CW-1:0]    cls,
  input logic [LANES-1:0] lane_vld,
  input logic [LANES-1:0] lane_wb,
  input logic             one_vld,
  input logic             one_wb
);
  logic any_iss, any_wb;
  always_comb begin
    any_iss = (|lane_vld) || one_vld;
    any_wb  = (|lane_wb) || one_wb;
  end

  assert_lane_prefix_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane_vld & (lane_vld + 1'b1)) == '0));

  assert_wb_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any_iss |=> (lane_wb == $past(lane_vld)) && (one_wb == $past(one_vld)));

  assert_single_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    one_vld |-> (lane_vld == '0));

  assert_class_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start_ok) |=> (!busy || $stable(cls)));

  assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_start |=> done && !any_iss && !any_wb);

  assert_busy_cover_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (any_iss || any_wb || done) |-> busy);

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !any_iss && !any_wb);
endmodule

bind lane_chunk_sequencer lcs_checker #(.LANES(LANES), .CW(CW)) u_lcs_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_ok   (accept_w),
  .zero_start (zero_start_w),
  .busy       (busy_o),
  .done       (done_o),
  .cls        (class_o),
  .lane_vld   (lane_vld_o),
  .lane_wb    (lane_wb_o),
  .one_vld    (one_vld_o),
  .one_wb     (one_wb_o)
);

// File: tb/lane_chunk_sequencer_tb.sv
module lane_chunk_sequencer_tb;
  localparam int L  = 4;
  localparam int IW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [4:0]  vl_i = '0;
  logic [2:0]  class_i = '0;
  logic        busy_o, done_o, one_vld_o, one_wb_o;
  logic [2:0]  class_o;
  logic [3:0]  lane_vld_o, lane_wb_o, one_idx_o, one_wb_idx_o;
  logic [15:0] lane_idx_o, lane_wb_idx_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // reference model state
  bit m_busy = 0;
  int m_c, m_n, m_vl, m_done_c, m_cls;
  bit m_one;

  lane_chunk_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i), .class_i(class_i),
    .busy_o(busy_o), .done_o(done_o), .class_o(class_o),
    .lane_vld_o(lane_vld_o), .lane_idx_o(lane_idx_o),
    .one_vld_o(one_vld_o), .one_idx_o(one_idx_o),
    .lane_wb_o(lane_wb_o), .lane_wb_idx_o(lane_wb_idx_o),
    .one_wb_o(one_wb_o), .one_wb_idx_o(one_wb_idx_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // model advances on each edge, from the requirement arithmetic only
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0;
    end else if (m_busy) begin
      if (m_c == m_done_c) m_busy = 0;
      else m_c++;
    end else if (start_i) begin
      m_busy   = 1;
      m_c      = 0;
      m_vl     = (int'(vl_i) > 16) ? 16 : int'(vl_i);
      m_cls    = int'(class_i);
      m_one    = (class_i == 3'd6) || (class_i == 3'd7);
      m_n      = (m_vl == 0) ? 0 : (m_one ? m_vl : (m_vl + L - 1) / L);
      m_done_c = (m_vl == 0) ? 0 : m_n + 1;
    end
  end

  // comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit ei, ew;
      int e;
      chk(busy_o == m_busy, "R8 busy", busy_o, m_busy);
      chk(done_o == (m_busy && m_c == m_done_c), "R7/R9 done", done_o, m_busy && m_c == m_done_c);
      if (m_busy) chk(int'(class_o) == m_cls, "R6 class", class_o, m_cls);
      for (int k = 0; k < L; k++) begin
        e  = m_c * L + k;
        ei = m_busy && !m_one && m_c < m_n && e < m_vl;
        chk(lane_vld_o[k] == ei, "R2/R3/R5/R6 lane issue valid", lane_vld_o[k], ei);
        if (ei) chk(int'(lane_idx_o[k*IW +: IW]) == e, "R2 lane index", lane_idx_o[k*IW +: IW], e);
        e  = (m_c - 1) * L + k;
        ew = m_busy && !m_one && m_c >= 1 && m_c <= m_n && e < m_vl;
        chk(lane_wb_o[k] == ew, "R3/R4 lane write-back valid", lane_wb_o[k], ew);
        if (ew) chk(int'(lane_wb_idx_o[k*IW +: IW]) == e, "R4 lane write-back index", lane_wb_idx_o[k*IW +: IW], e);
      end
      ei = m_busy && m_one && m_c < m_n;
      chk(one_vld_o == ei, "R5/R6 shared issue valid", one_vld_o, ei);
      if (ei) chk(int'(one_idx_o) == m_c, "R5 shared index", one_idx_o, m_c);
      ew = m_busy && m_one && m_c >= 1 && m_c <= m_n;
      chk(one_wb_o == ew, "R4/R5 shared write-back valid", one_wb_o, ew);
      if (ew) chk(int'(one_wb_idx_o) == m_c - 1, "R4 shared write-back index", one_wb_idx_o, m_c - 1);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // one operation; poke = start pulses sent while busy (must be ignored, R8)
  task automatic run_op(input int cls, input int len, input bit poke);
    @(negedge clk);
    start_i = 1'b1; vl_i = 5'(len); class_i = 3'(cls);
    @(negedge clk);
    start_i = poke; vl_i = 5'd3; class_i = 3'd7;
    while (busy_o) @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && lane_vld_o == 0 && lane_wb_o == 0 && !one_vld_o && !one_wb_o,
        "R1 during reset", busy_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 0 && lane_vld_o == 0 && lane_wb_o == 0, "R1 after reset", busy_o, 0);
    for (int len = 1; len <= 16; len++) run_op(len % 6, len, len[0]);
    run_op(2, 0, 1'b0);          // R7 zero length
    run_op(6, 0, 1'b1);          // R7 zero length, uncommon class
    run_op(6, 5, 1'b0);          // R5 shared unit
    run_op(7, 16, 1'b1);         // R5/R8 shared with pokes
    run_op(1, 20, 1'b0);         // R10 clamp to 16
    run_op(6, 31, 1'b1);         // R10 clamp on shared path
    // back-to-back: start held through the done cycle and beyond (R8/R9)
    @(negedge clk);
    start_i = 1'b1; vl_i = 5'd7; class_i = 3'd3;
    repeat (12) @(negedge clk);
    start_i = 1'b0;
    while (busy_o) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule